// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Software programs a prescale divisor and a 16-bit reload count, then sets an enable bit. While enabled, a down-counter steps once for every group of prescaled tick pulses. When the counter runs out, the block raises a sticky interrupt and reloads itself. If the counter runs out again before software clears that interrupt, the block pulses a reset-request line for one clock cycle.

Every bus write must carry the key value 0x1234 in bits 31:16. A write without that key changes nothing. Only the low 16 bits hold data.

Newly written divisor and reload values do not take effect on their own. Software activates them through a refresh register. That register is split into three 2-bit groups, and a group acts when its value moves to a different code of 1 or 2. Inverting bits 5:0 of the value read back therefore fires all three groups at once.

The `tick_i` input is a one-cycle enable, pulsed once per period of the slow tick clock (nominally 32768 Hz). It is synchronous to `clk`.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, reads return configuration 0x0F00 (divisor field 15), reload 0xFFFF, refresh 0x0015 (every group at 1) and start 0x0000. `irq_o` and `rst_req_o` are low.
- R2: A write takes effect only when `wr_en_i` is high and `wr_data_i[31:16]` equals 0x1234. Any other write leaves every register and all counting state unchanged.
- R3: Reads are combinational and return the register in bits 15:0 and zero in bits 31:16. The byte offsets are 0x04 for configuration, 0x08 for reload, 0x18 for refresh and 0x1C for start. Any other offset reads as zero.
- R4: While start bit 0 is set, the counter steps once every k+1 `tick_i` pulses, where k is the active divisor field (configuration bits 15:8).
- R5: Configuration bits 15:8 become the active divisor only when refresh bits 5:4 change to a new value of 1 or 2. That event also restarts the prescaler.
- R6: When refresh bits 3:2 change to a new value of 1 or 2, the counter loads the reload register. That value also becomes the reload value used on expiry, and the prescaler restarts. This load takes priority over a step in the same cycle.
- R7: A prescaled step that finds the counter at zero is an expiry. The counter reloads and `irq_o` goes high and stays high.
- R8: An expiry while `irq_o` is already high drives `rst_req_o` high for exactly one cycle.
- R9: When refresh bits 1:0 change to a new value of 1 or 2, `irq_o` clears. An expiry in the same cycle takes priority and leaves it set.
- R10: A refresh group written with its current value, or with 0 or 3, causes no action. The written bits are still stored and read back.
- R11: With start bit 0 clear, the prescaler and counter hold, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle pulse per slow tick period |
| addr_i | input | 8 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data: key in bits 31:16, value in bits 15:0 |
| rd_data_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | One-cycle reset request on a second expiry |

## Verification
The in-module assertions check these properties on every cycle:
- a rejected write leaves the registers stable;
- the prescaler never exceeds its active divisor;
- the counter holds while disabled and steps down by exactly one on each prescaled step;
- the interrupt stays set until cleared;
- a reset request only follows a cycle with the interrupt already set.

Other behaviours can only be shown by the bench's scenarios:
- the exact expiry cycle for a given divisor and reload;
- the deferred activation of new settings;
- the refusal to act on repeated, 0 or 3 group codes;
- the priority of expiry over an interrupt clear.

The bench checks these against a reference model built from the requirements, under directed sequences and seeded random traffic.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int          BUS_W   = 32;
  localparam int          HALF_W  = 16;
  localparam logic [15:0] WR_KEY  = 16'h1234;
  localparam int          OFF_CFG = 'h04;
  localparam int          OFF_REL = 'h08;
  localparam int          OFF_REF = 'h18;
  localparam int          OFF_RUN = 'h1C;
  localparam int          N_GRP   = 3;
  // group index order is decoded: 0 clears irq, 1 reloads counter, 2 latches config
  localparam int          G_IRQ   = 0;
  localparam int          G_CNT   = 1;
  localparam int          G_CFG   = 2;

  // a group acts when it changes to a new code of 1 or 2
  function automatic logic grp_fires(input logic [1:0] prev, input logic [1:0] nxt);
    return (nxt != prev) && (nxt == 2'b01 || nxt == 2'b10);
  endfunction
endpackage

// File: rtl/kwdt_regbank.sv
module kwdt_regbank
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [HALF_W-1:0] cfg_o,
  output logic [HALF_W-1:0] reload_o,
  output logic              run_o,
  output logic              latch_cfg_o,
  output logic              load_cnt_o,
  output logic              clr_irq_o
);
  logic [HALF_W-1:0] cfg_q, cfg_d, rel_q, rel_d, ref_q, ref_d, run_q, run_d;
  logic              key_ok, wr_ok;
  logic              sel_cfg, sel_rel, sel_ref, sel_run;
  logic [N_GRP-1:0]  fire;

  assign key_ok  = (wr_data_i[BUS_W-1:HALF_W] == WR_KEY);
  assign wr_ok   = wr_en_i && key_ok;
  assign sel_cfg = (addr_i == ADDR_W'(OFF_CFG));
  assign sel_rel = (addr_i == ADDR_W'(OFF_REL));
  assign sel_ref = (addr_i == ADDR_W'(OFF_REF));
  assign sel_run = (addr_i == ADDR_W'(OFF_RUN));

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign fire[g] = wr_ok && sel_ref && grp_fires(ref_q[2*g +: 2], wr_data_i[2*g +: 2]);
  end

  always_comb begin
    cfg_d = cfg_q;
    rel_d = rel_q;
    ref_d = ref_q;
    run_d = run_q;
    if (wr_ok) begin
      if (sel_cfg) cfg_d = wr_data_i[HALF_W-1:0];
      if (sel_rel) rel_d = wr_data_i[HALF_W-1:0];
      if (sel_ref) ref_d = wr_data_i[HALF_W-1:0];
      if (sel_run) run_d = wr_data_i[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 16'h0F00;
      rel_q <= 16'hFFFF;
      ref_q <= 16'h0015;
      run_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      rel_q <= rel_d;
      ref_q <= ref_d;
      run_q <= run_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (sel_cfg) rd_data_o[HALF_W-1:0] = cfg_q;
    if (sel_rel) rd_data_o[HALF_W-1:0] = rel_q;
    if (sel_ref) rd_data_o[HALF_W-1:0] = ref_q;
    if (sel_run) rd_data_o[HALF_W-1:0] = run_q;
  end

  assign cfg_o       = cfg_q;
  assign reload_o    = rel_q;
  assign run_o       = run_q[0];
  assign latch_cfg_o = fire[G_CFG];
  assign load_cnt_o  = fire[G_CNT];
  assign clr_irq_o   = fire[G_IRQ];

  assert_badkey_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !key_ok) |=> ($stable(cfg_q) && $stable(rel_q) && $stable(ref_q) && $stable(run_q)));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             latch_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic [DIV_W-1:0] div_q, div_d, pre_q, pre_d;
  logic             step;

  always_comb begin
    div_d = latch_i ? div_i : div_q;
    pre_d = pre_q;
    step  = 1'b0;
    if (latch_i || restart_i) begin
      pre_d = '0;
    end else if (run_i && tick_i) begin
      if (pre_q == div_q) begin
        pre_d = '0;
        step  = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(15);
      pre_q <= '0;
    end else begin
      div_q <= div_d;
      pre_q <= pre_d;
    end
  end

  assign step_o = step;

  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n) pre_q <= div_q);
  assert_pre_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !latch_i && !restart_i) |=> $stable(pre_q));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, arel_q, arel_d;
  logic             irq_q, irq_d, rreq_q, rreq_d, expire;

  always_comb begin
    cnt_d  = cnt_q;
    arel_d = arel_q;
    expire = 1'b0;
    if (load_i) begin
      cnt_d  = reload_i;
      arel_d = reload_i;
    end else if (step_i) begin
      if (cnt_q == '0) begin
        cnt_d  = arel_q;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    irq_d  = expire ? 1'b1 : (clr_i ? 1'b0 : irq_q);
    rreq_d = expire && irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      arel_q <= '1;
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      arel_q <= arel_d;
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rreq_q;

  assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q));
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_i) |=> irq_q);
  assert_rreq_after_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rreq_q) |-> $past(irq_q));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int DIV_LSB = HALF_W - DIV_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [HALF_W-1:0] cfg, reload;
  logic              run, latch_cfg, load_cnt, clr_irq, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kwdt_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .cfg_o(cfg), .reload_o(reload),
    .run_o(run), .latch_cfg_o(latch_cfg), .load_cnt_o(load_cnt), .clr_irq_o(clr_irq)
  );

  kwdt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick_i), .run_i(run),
    .latch_i(latch_cfg), .restart_i(load_cnt),
    .div_i(cfg[HALF_W-1:DIV_LSB]), .step_o(step)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .step_i(step), .load_i(load_cnt),
    .clr_i(clr_irq), .reload_i(reload[CNT_W-1:0]),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rreq;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  keyed_wdt uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq), .rst_req_o(rreq)
  );

  // reference model from the requirements
  logic [15:0] m_cfg, m_rel, m_ref, m_run, m_cnt, m_arel;
  logic [7:0]  m_div, m_pre;
  logic        m_irq, m_rreq;

  function automatic logic fires(input logic [1:0] o, input logic [1:0] n);
    return (o != n) && (n == 2'd1 || n == 2'd2);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h04:   return {16'h0, m_cfg};
      8'h08:   return {16'h0, m_rel};
      8'h18:   return {16'h0, m_ref};
      8'h1C:   return {16'h0, m_run};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 16'h0F00; m_rel = 16'hFFFF; m_ref = 16'h0015; m_run = 0;
      m_cnt = 16'hFFFF; m_arel = 16'hFFFF; m_div = 8'd15; m_pre = 0;
      m_irq = 0; m_rreq = 0;
    end else begin
      logic ok, f_cfg, f_cnt, f_clr, stp, exp_;
      ok    = wr_en && wdata[31:16] == 16'h1234;
      f_cfg = ok && addr == 8'h18 && fires(m_ref[5:4], wdata[5:4]);
      f_cnt = ok && addr == 8'h18 && fires(m_ref[3:2], wdata[3:2]);
      f_clr = ok && addr == 8'h18 && fires(m_ref[1:0], wdata[1:0]);
      stp = 0; exp_ = 0;
      if (f_cfg || f_cnt) m_pre = 0;
      else if (m_run[0] && tick) begin
        if (m_pre == m_div) begin m_pre = 0; stp = 1; end
        else m_pre = m_pre + 1;
      end
      if (f_cfg) m_div = m_cfg[15:8];
      if (f_cnt) begin m_cnt = m_rel; m_arel = m_rel; end
      else if (stp) begin
        if (m_cnt == 0) begin m_cnt = m_arel; exp_ = 1; end
        else m_cnt = m_cnt - 1;
      end
      m_rreq = exp_ && m_irq;
      m_irq  = exp_ ? 1'b1 : (f_clr ? 1'b0 : m_irq);
      if (ok) case (addr)
        8'h04: m_cfg = wdata[15:0];
        8'h08: m_rel = wdata[15:0];
        8'h18: m_ref = wdata[15:0];
        8'h1C: m_run = wdata[15:0];
        default: ;
      endcase
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    nchk++;
    if (act !== exp_v) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic cyc(input string req);
    @(negedge clk);
    check(req, {rdata, 30'd0, irq, rreq}, {m_read(addr), 30'd0, m_irq, m_rreq});
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] v, input string req);
    addr = a; wdata = {16'h1234, v}; wr_en = 1'b1;
    cyc(req);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 and R3: reset values and read layout
    addr = 8'h04; #1 check("R1", rdata, 32'h0000_0F00);
    addr = 8'h08; #1 check("R1", rdata, 32'h0000_FFFF);
    addr = 8'h18; #1 check("R1", rdata, 32'h0000_0015);
    addr = 8'h1C; #1 check("R1", rdata, 32'h0);
    addr = 8'h0C; #1 check("R3", rdata, 32'h0);
    check("R1", {irq, rreq}, 2'b00);
    // R2: wrong key ignored
    addr = 8'h08; wdata = 32'h4321_0003; wr_en = 1'b1; cyc("R2");
    wr_en = 1'b0; #1 check("R2", rdata, 32'h0000_FFFF);
    // program k=1, reload 3; new values inactive until refresh (R5, R6)
    wr(8'h04, 16'h0100, "R5");
    wr(8'h08, 16'h0003, "R6");
    tick = 1'b1;
    wr(8'h1C, 16'h0001, "R4");
    wr(8'h18, 16'h002A, "R6");
    // R7: expiry after (3+1)*(1+1) = 8 ticks
    for (int i = 1; i <= 8; i++) begin
      cyc("R7");
      if (i == 7) check("R7", irq, 1'b0);
      if (i == 8) check("R7", irq, 1'b1);
    end
    // R8: second expiry pulses reset request once
    for (int i = 1; i <= 9; i++) begin
      cyc("R8");
      if (i == 8) check("R8", rreq, 1'b1);
      if (i == 9) check("R8", rreq, 1'b0);
    end
    // R10: same value and 0/3 codes do nothing; bits still stored
    wr(8'h18, 16'h002A, "R10");
    wr(8'h18, 16'h003F, "R10");
    #1 check("R10", rdata, 32'h0000_003F);
    check("R10", irq, 1'b1);
    // R9: clear irq through bits 1:0
    wr(8'h18, 16'h003E, "R9");
    check("R9", irq, 1'b0);
    // R11: disabled holds
    wr(8'h1C, 16'h0000, "R11");
    for (int i = 0; i < 60; i++) cyc("R11");
    check("R11", {irq, rreq}, 2'b00);
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [7:0] offs [5];
      offs = '{8'h04, 8'h08, 8'h18, 8'h1C, 8'h10};
      r = $urandom_range(0, 99);
      tick = ($urandom_range(0, 3) != 0);
      addr = offs[$urandom_range(0, 4)];
      wr_en = (r < 25);
      wdata = {(r < 22) ? 16'h1234 : 16'($urandom), 16'($urandom)};
      if (addr == 8'h04) wdata[15:8] = 8'($urandom_range(0, 3));
      if (addr == 8'h08) wdata[15:0] = 16'($urandom_range(0, 6));
      if (addr == 8'h1C && r < 22) wdata[0] = ($urandom_range(0, 4) != 0);
      cyc((addr == 8'h18) ? "R10" : "R4");
      wr_en = 1'b0;
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd1357));
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule